// File: doc/BRIEF.md
# Load/Store Instruction Sequencer

This block is a small multicycle execute stage for a CPU with 16-bit instruction words and eight 32-bit registers. It runs on its own from reset. It fetches an instruction and, for the forms that carry one, the 32-bit extension word that follows it. It then drives one data access if the instruction needs it, writes the register file and moves the program counter. It covers byte and halfword loads and stores in immediate, absolute and register-indirect forms, plus a register-indirect jump. Every other opcode retires as an illegal instruction.

The instruction port is a combinational read that returns 32 big-endian bits starting at the requested byte address. The upper half is the instruction when the PC is requested, and the whole word is the extension when PC+2 is requested. The data port is also combinational. The memory unit returns the loaded value low-aligned and flags range and alignment faults in the same cycle. The block zero-extends loaded values and masks store data down to the access size.

Top module: `ldst_seq`

## Requirements
- R1: While rst_ni is low, pc_o is RESET_PC (default 0), and retire_o, dmem_req_o, rf_we_o and exc_o are 0.
- R2: The opcode is instruction bits 15:9, field A is bits 8:6 and field B is bits 5:3; the extension word is fetched from PC+2.
- R3: Opcodes 0x1A and 0x1F write the full 32-bit extension word to register A, make no data access, and set the PC to PC+6.
- R4: Opcodes 0x1C (byte) and 0x21 (halfword) read from the address held in the extension word, write the zero-extended value to register A, and set the PC to PC+6.
- R5: Opcodes 0x1B (byte) and 0x20 (halfword) read from the address in register B, write the zero-extended value to register A, and set the PC to PC+2.
- R6: Opcodes 0x1D (byte) and 0x22 (halfword) write the low byte or halfword of register B, zero-extended on dmem_wdata_o, to the address in register A. They make no register write and set the PC to PC+2.
- R7: Opcodes 0x1E (byte) and 0x23 (halfword) write the low byte or halfword of register A to the address held in the extension word. They make no register write and set the PC to PC+6.
- R8: Opcode 0x24 sets the PC to the value of register A (computed as A-2 followed by the common +2 step), with no data access and no register write.
- R9: Any other opcode retires with illegal_o=1, exc_o=1 and exc_code_o=1. It makes no register write and no data access, and sets the PC to PC+2.
- R10: A data fault sets exc_o at retire, with exc_code_o=2 for a range fault and 3 for an alignment fault (range wins when both are present). A faulting load does not write its register, and the PC still advances as for a good access.
- R11: dmem_size_o is 0 for byte and 1 for halfword accesses. An instruction takes 2 cycles (jump, illegal), 3 cycles (immediate, register-indirect) or 4 cycles (absolute), counted from fetch to the retire cycle inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction-side byte address (PC or PC+2) |
| imem_rdata_i | input | 32 | Big-endian 32 bits starting at imem_addr_o |
| dmem_req_o | output | 1 | Data access strobe, one cycle per access |
| dmem_we_o | output | 1 | 1 = store, 0 = load |
| dmem_size_o | output | 1 | 0 = byte, 1 = halfword |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data, zero-extended from access size |
| dmem_rdata_i | input | 16 | Low-aligned load data from the memory unit |
| dmem_range_err_i | input | 1 | Address outside memory, valid with dmem_req_o |
| dmem_align_err_i | input | 1 | Misaligned access, valid with dmem_req_o |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 3 | Register written |
| rf_wdata_o | output | 32 | Value written |
| retire_o | output | 1 | Instruction retires this cycle |
| pc_o | output | 32 | Current program counter |
| illegal_o | output | 1 | Retiring instruction has an undecoded opcode |
| exc_o | output | 1 | Retiring instruction raised an exception |
| exc_code_o | output | 2 | 0 none, 1 illegal, 2 range fault, 3 alignment fault |

## Verification
The register write, the exception outputs and the illegal flag appear in the retire cycle. That cycle is the second, third or fourth after fetch, depending on the form. The new PC shows one cycle after retire. The data strobe comes one cycle before retire. The bench samples on the falling edge. It records any data strobe seen while it waits, checks the writeback and exception outputs in the same half-cycle where retire_o is high, reads pc_o one falling edge later, and compares the number of falling edges between retires with the expected cycle count of each form.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int INSN_W  = 16;
  localparam int OPC_HI  = 15;
  localparam int OPC_LO  = 9;
  localparam int FA_HI   = 8;
  localparam int FA_LO   = 6;
  localparam int FB_HI   = 5;
  localparam int FB_LO   = 3;
  localparam int OPC_W   = OPC_HI - OPC_LO + 1;
  localparam int RIDX_W  = FA_HI - FA_LO + 1;
  localparam int NREG    = 1 << RIDX_W;
  localparam int LDATA_W = 16;

  localparam logic [OPC_W-1:0] OPC_IMM_B = 7'h1A;
  localparam logic [OPC_W-1:0] OPC_IND_LB = 7'h1B;
  localparam logic [OPC_W-1:0] OPC_ABS_LB = 7'h1C;
  localparam logic [OPC_W-1:0] OPC_IND_SB = 7'h1D;
  localparam logic [OPC_W-1:0] OPC_ABS_SB = 7'h1E;
  localparam logic [OPC_W-1:0] OPC_IMM_H = 7'h1F;
  localparam logic [OPC_W-1:0] OPC_IND_LH = 7'h20;
  localparam logic [OPC_W-1:0] OPC_ABS_LH = 7'h21;
  localparam logic [OPC_W-1:0] OPC_IND_SH = 7'h22;
  localparam logic [OPC_W-1:0] OPC_ABS_SH = 7'h23;
  localparam logic [OPC_W-1:0] OPC_JREG   = 7'h24;

  typedef enum logic [2:0] {
    K_IMM, K_ABS_LD, K_IND_LD, K_IND_ST, K_ABS_ST, K_JREG, K_ILL
  } kind_e;

  typedef enum logic [1:0] {S_FETCH, S_EXT, S_MEM, S_WB} state_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0, EXC_ILL = 2'd1, EXC_RANGE = 2'd2, EXC_ALIGN = 2'd3
  } exc_e;

  typedef struct packed {
    kind_e kind;
    logic  half;
    logic  ext;
    logic  mem;
    logic  wr;
  } dec_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [INSN_W-1:FB_LO] insn_i,
  output dec_t                  dec_o,
  output logic [RIDX_W-1:0]     ra_o,
  output logic [RIDX_W-1:0]     rb_o
);
  logic [OPC_W-1:0] opc;

  assign opc  = insn_i[OPC_HI:OPC_LO];
  assign ra_o = insn_i[FA_HI:FA_LO];
  assign rb_o = insn_i[FB_HI:FB_LO];

  always_comb begin
    dec_o = '{kind: K_ILL, half: 1'b0, ext: 1'b0, mem: 1'b0, wr: 1'b0};
    unique case (opc)
      OPC_IMM_B, OPC_IMM_H: begin
        dec_o.kind = K_IMM;
        dec_o.ext  = 1'b1;
        dec_o.wr   = 1'b1;
      end
      OPC_ABS_LB, OPC_ABS_LH: begin
        dec_o.kind = K_ABS_LD;
        dec_o.ext  = 1'b1;
        dec_o.mem  = 1'b1;
        dec_o.wr   = 1'b1;
        dec_o.half = (opc == OPC_ABS_LH);
      end
      OPC_IND_LB, OPC_IND_LH: begin
        dec_o.kind = K_IND_LD;
        dec_o.mem  = 1'b1;
        dec_o.wr   = 1'b1;
        dec_o.half = (opc == OPC_IND_LH);
      end
      OPC_IND_SB, OPC_IND_SH: begin
        dec_o.kind = K_IND_ST;
        dec_o.mem  = 1'b1;
        dec_o.half = (opc == OPC_IND_SH);
      end
      OPC_ABS_SB, OPC_ABS_SH: begin
        dec_o.kind = K_ABS_ST;
        dec_o.ext  = 1'b1;
        dec_o.mem  = 1'b1;
        dec_o.half = (opc == OPC_ABS_SH);
      end
      OPC_JREG: dec_o.kind = K_JREG;
      default:  dec_o.kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int XLEN = 32,
  parameter int NR   = 8,
  localparam int AW  = $clog2(NR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] ra_val_o,
  output logic [XLEN-1:0] rb_val_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_val_o = regs_q[ra_i];
  assign rb_val_o = regs_q[rb_i];
endmodule

// File: rtl/ldst_lane.sv
module ldst_lane #(
  parameter int XLEN = 32,
  parameter int LW   = 16
) (
  input  logic            half_i,
  input  logic [XLEN-1:0] st_src_i,
  input  logic [LW-1:0]   ld_raw_i,
  output logic [XLEN-1:0] st_data_o,
  output logic [XLEN-1:0] ld_val_o
);
  localparam int BW = 8;

  always_comb begin
    if (half_i) begin
      st_data_o = XLEN'(st_src_i[LW-1:0]);
      ld_val_o  = XLEN'(ld_raw_i);
    end else begin
      st_data_o = XLEN'(st_src_i[BW-1:0]);
      ld_val_o  = XLEN'(ld_raw_i[BW-1:0]);
    end
  end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [XLEN-1:0]    imem_addr_o,
  input  logic [XLEN-1:0]    imem_rdata_i,
  output logic               dmem_req_o,
  output logic               dmem_we_o,
  output logic               dmem_size_o,
  output logic [XLEN-1:0]    dmem_addr_o,
  output logic [XLEN-1:0]    dmem_wdata_o,
  input  logic [LDATA_W-1:0] dmem_rdata_i,
  input  logic               dmem_range_err_i,
  input  logic               dmem_align_err_i,
  output logic               rf_we_o,
  output logic [RIDX_W-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               retire_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               illegal_o,
  output logic               exc_o,
  output logic [1:0]         exc_code_o
);
  localparam int          HW_HI  = XLEN - 1;
  localparam int          HW_LO  = XLEN - INSN_W;
  localparam logic [XLEN-1:0] STEP   = XLEN'(2);
  localparam logic [XLEN-1:0] EXT_SZ = XLEN'(4);

  state_e                 state_q, state_d;
  logic [INSN_W-1:FB_LO]  insn_q, insn_cur;
  logic [XLEN-1:0]        ext_q, ldv_q, pc_q, pc_nx, pc_base;
  exc_e                   err_q, err_mem, exc_cur;
  dec_t                   dec;
  logic [RIDX_W-1:0]      ra, rb;
  logic [XLEN-1:0]        ra_val, rb_val, st_src, ld_val, st_data;
  logic                   wb_we;

  // decode the incoming word during fetch, the held word afterwards
  assign insn_cur = (state_q == S_FETCH) ? imem_rdata_i[HW_HI:HW_LO+FB_LO] : insn_q;

  ldst_decode u_dec (
    .insn_i (insn_cur),
    .dec_o  (dec),
    .ra_o   (ra),
    .rb_o   (rb)
  );

  ldst_regfile #(.XLEN(XLEN), .NR(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_i     (ra),
    .rb_i     (rb),
    .ra_val_o (ra_val),
    .rb_val_o (rb_val),
    .we_i     (wb_we),
    .waddr_i  (ra),
    .wdata_i  (rf_wdata_o)
  );

  assign st_src = (dec.kind == K_IND_ST) ? rb_val : ra_val;

  ldst_lane #(.XLEN(XLEN), .LW(LDATA_W)) u_lane (
    .half_i    (dec.half),
    .st_src_i  (st_src),
    .ld_raw_i  (dmem_rdata_i),
    .st_data_o (st_data),
    .ld_val_o  (ld_val)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH: state_d = dec.ext ? S_EXT : (dec.mem ? S_MEM : S_WB);
      S_EXT:   state_d = dec.mem ? S_MEM : S_WB;
      S_MEM:   state_d = S_WB;
      S_WB:    state_d = S_FETCH;
      default: state_d = S_FETCH;
    endcase
  end

  always_comb begin
    if (dmem_range_err_i)      err_mem = EXC_RANGE;
    else if (dmem_align_err_i) err_mem = EXC_ALIGN;
    else                       err_mem = EXC_NONE;
  end

  // jump applies -2 so the common step lands on the target
  always_comb begin
    if (dec.kind == K_JREG) pc_base = ra_val - STEP;
    else if (dec.ext)       pc_base = pc_q + EXT_SZ;
    else                    pc_base = pc_q;
  end
  assign pc_nx = pc_base + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      insn_q  <= '0;
      ext_q   <= '0;
      ldv_q   <= '0;
      err_q   <= EXC_NONE;
      pc_q    <= RESET_PC;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_FETCH: begin
          insn_q <= imem_rdata_i[HW_HI:HW_LO+FB_LO];
          err_q  <= EXC_NONE;
        end
        S_EXT:   ext_q <= imem_rdata_i;
        S_MEM: begin
          ldv_q <= ld_val;
          err_q <= err_mem;
        end
        S_WB:    pc_q <= pc_nx;
        default: ;
      endcase
    end
  end

  assign imem_addr_o = (state_q == S_EXT) ? pc_q + STEP : pc_q;

  assign dmem_req_o   = (state_q == S_MEM);
  assign dmem_we_o    = (state_q == S_MEM) &&
                        (dec.kind == K_IND_ST || dec.kind == K_ABS_ST);
  assign dmem_size_o  = dec.half;
  assign dmem_wdata_o = st_data;
  always_comb begin
    unique case (dec.kind)
      K_IND_LD: dmem_addr_o = rb_val;
      K_IND_ST: dmem_addr_o = ra_val;
      default:  dmem_addr_o = ext_q;
    endcase
  end

  assign retire_o   = (state_q == S_WB);
  assign exc_cur    = (dec.kind == K_ILL) ? EXC_ILL : err_q;
  assign exc_o      = retire_o && (exc_cur != EXC_NONE);
  assign exc_code_o = retire_o ? exc_cur : EXC_NONE;
  assign illegal_o  = retire_o && (dec.kind == K_ILL);
  assign wb_we      = retire_o && dec.wr && (exc_cur == EXC_NONE);
  assign rf_we_o    = wb_we;
  assign rf_waddr_o = ra;
  assign rf_wdata_o = (dec.kind == K_IMM) ? ext_q : ldv_q;
  assign pc_o       = pc_q;

  // R11
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_req_o |=> !dmem_req_o);

  // R11
  retire_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);

  // R10
  wb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !exc_o);

  // R9
  ill_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (exc_o && exc_code_o == 2'd1));

  // R9
  ill_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(state_q) == S_FETCH);

  // R10
  fault_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && (dmem_range_err_i || dmem_align_err_i)) |=> exc_o);
endmodule

// File: tb/ldst_seq_tb.sv
module ldst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [15:0] ins;
    logic        hx;
    logic [31:0] ext;
    logic [31:0] pcn;
    logic [2:0]  cyc;
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [1:0]  exc;
    logic        mem;
    logic        mwe;
    logic        msz;
    logic [31:0] ma;
    logic [31:0] mwd;
    logic [3:0]  req;
  } vec_t;

  // instruction words: opcode<<9 | A<<6 | B<<3
  localparam vec_t VECS [NV] = '{
    '{16'h3440,1'b1,32'h12345678, 32'd6,  3'd3,1'b1,3'd1,32'h12345678,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd3},
    '{16'h3E80,1'b1,32'h00002001, 32'd12, 3'd3,1'b1,3'd2,32'h00002001,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd3},
    '{16'h34C0,1'b1,32'hDEADBEEF, 32'd18, 3'd3,1'b1,3'd3,32'hDEADBEEF,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd2},
    '{16'h3710,1'b0,32'h0,        32'd20, 3'd3,1'b1,3'd4,32'h0000003D,2'd0,1'b1,1'b0,1'b0,32'h2001,    32'h0,    4'd5},
    '{16'h4150,1'b0,32'h0,        32'd22, 3'd3,1'b0,3'd5,32'h0,       2'd3,1'b1,1'b0,1'b1,32'h2001,    32'h0,    4'd10},
    '{16'h3F80,1'b1,32'h00004000, 32'd28, 3'd3,1'b1,3'd6,32'h00004000,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd3},
    '{16'h4170,1'b0,32'h0,        32'd30, 3'd3,1'b1,3'd5,32'h00007C3C,2'd0,1'b1,1'b0,1'b1,32'h4000,    32'h0,    4'd5},
    '{16'h39C0,1'b1,32'h00000102, 32'd36, 3'd4,1'b1,3'd7,32'h0000003E,2'd0,1'b1,1'b0,1'b0,32'h102,     32'h0,    4'd4},
    '{16'h4200,1'b1,32'h00000010, 32'd42, 3'd4,1'b1,3'd0,32'h00003C2C,2'd0,1'b1,1'b0,1'b1,32'h10,      32'h0,    4'd4},
    '{16'h3B98,1'b0,32'h0,        32'd44, 3'd3,1'b0,3'd0,32'h0,       2'd0,1'b1,1'b1,1'b0,32'h4000,    32'hEF,   4'd6},
    '{16'h4488,1'b0,32'h0,        32'd46, 3'd3,1'b0,3'd0,32'h0,       2'd3,1'b1,1'b1,1'b1,32'h2001,    32'h5678, 4'd10},
    '{16'h3CC0,1'b1,32'h00000777, 32'd52, 3'd4,1'b0,3'd0,32'h0,       2'd0,1'b1,1'b1,1'b0,32'h777,     32'hEF,   4'd7},
    '{16'h4640,1'b1,32'h00000100, 32'd58, 3'd4,1'b0,3'd0,32'h0,       2'd0,1'b1,1'b1,1'b1,32'h100,     32'h5678, 4'd7},
    '{16'h3900,1'b1,32'hF0000000, 32'd64, 3'd4,1'b0,3'd0,32'h0,       2'd2,1'b1,1'b0,1'b0,32'hF0000000,32'h0,    4'd10},
    '{16'h4A00,1'b0,32'h0,        32'd66, 3'd2,1'b0,3'd0,32'h0,       2'd1,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd9},
    '{16'h0000,1'b0,32'h0,        32'd68, 3'd2,1'b0,3'd0,32'h0,       2'd1,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd9},
    '{16'h3F80,1'b1,32'h00000080, 32'd74, 3'd3,1'b1,3'd6,32'h00000080,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd3},
    '{16'h4980,1'b0,32'h0,        32'd128,3'd2,1'b0,3'd0,32'h0,       2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd8},
    '{16'h3660,1'b0,32'h0,        32'd130,3'd3,1'b1,3'd1,32'h00000001,2'd0,1'b1,1'b0,1'b0,32'h3D,      32'h0,    4'd10},
    '{16'h4740,1'b1,32'h00000200, 32'd136,3'd4,1'b0,3'd0,32'h0,       2'd0,1'b1,1'b1,1'b1,32'h200,     32'h7C3C, 4'd7},
    '{16'h3480,1'b1,32'hF0000001, 32'd142,3'd3,1'b1,3'd2,32'hF0000001,2'd0,1'b0,1'b0,1'b0,32'h0,       32'h0,    4'd3},
    '{16'h40D0,1'b0,32'h0,        32'd144,3'd3,1'b0,3'd0,32'h0,       2'd2,1'b1,1'b0,1'b1,32'hF0000001,32'h0,    4'd10},
    '{16'h4590,1'b0,32'h0,        32'd146,3'd3,1'b0,3'd0,32'h0,       2'd0,1'b1,1'b1,1'b1,32'h80,      32'h0001, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, rf_wdata, pc;
  logic        dmem_req, dmem_we, dmem_size, range_err, align_err;
  logic [15:0] dmem_rdata;
  logic        rf_we, retire, illegal, exc;
  logic [2:0]  rf_waddr;
  logic [1:0]  exc_code;
  logic [15:0] imem [256];
  logic [7:0]  iidx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instruction memory: big-endian, 32 bits from the requested byte address
  assign iidx       = imem_addr[8:1];
  assign imem_rdata = {imem[iidx], imem[8'(iidx + 8'd1)]};

  // memory unit model
  assign dmem_rdata = dmem_addr[15:0] ^ 16'h3C3C;
  assign range_err  = dmem_req && (dmem_addr[31:28] == 4'hF);
  assign align_err  = dmem_req && dmem_size && dmem_addr[0];

  ldst_seq dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .imem_addr_o      (imem_addr),
    .imem_rdata_i     (imem_rdata),
    .dmem_req_o       (dmem_req),
    .dmem_we_o        (dmem_we),
    .dmem_size_o      (dmem_size),
    .dmem_addr_o      (dmem_addr),
    .dmem_wdata_o     (dmem_wdata),
    .dmem_rdata_i     (dmem_rdata),
    .dmem_range_err_i (range_err),
    .dmem_align_err_i (align_err),
    .rf_we_o          (rf_we),
    .rf_waddr_o       (rf_waddr),
    .rf_wdata_o       (rf_wdata),
    .retire_o         (retire),
    .pc_o             (pc),
    .illegal_o        (illegal),
    .exc_o            (exc),
    .exc_code_o       (exc_code)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] cur;
    int          cnt;
    bit          seen, s_we, s_sz;
    logic [31:0] s_a, s_d;
    string       rq;

    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
    cur = 32'h0;
    for (int i = 0; i < NV; i++) begin
      imem[cur[8:1]] = VECS[i].ins;
      if (VECS[i].hx) begin
        imem[8'(cur[8:1] + 8'd1)] = VECS[i].ext[31:16];
        imem[8'(cur[8:1] + 8'd2)] = VECS[i].ext[15:0];
      end
      cur = VECS[i].pcn;
    end

    // R1: outputs while reset is held
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc, 32'h0);
    chk("R1", "retire in reset", {31'b0, retire}, 32'h0);
    chk("R1", "dmem_req in reset", {31'b0, dmem_req}, 32'h0);
    chk("R1", "rf_we in reset", {31'b0, rf_we}, 32'h0);
    chk("R1", "exc in reset", {31'b0, exc}, 32'h0);
    // R2: first fetch goes to the reset PC
    chk("R2", "fetch addr after reset", imem_addr, 32'h0);
    rst_n = 1'b1;

    cnt = 1;
    for (int i = 0; i < NV; i++) begin
      rq   = req_name(VECS[i].req);
      seen = 1'b0; s_we = 1'b0; s_sz = 1'b0; s_a = '0; s_d = '0;
      while (!retire) begin
        @(negedge clk);
        cnt++;
        if (dmem_req) begin
          seen = 1'b1; s_we = dmem_we; s_sz = dmem_size;
          s_a = dmem_addr; s_d = dmem_wdata;
        end
      end
      chk("R11", $sformatf("cycles vec %0d", i), 32'(cnt), 32'(VECS[i].cyc));
      chk(rq, $sformatf("rf_we vec %0d", i), {31'b0, rf_we}, {31'b0, VECS[i].we});
      if (VECS[i].we) begin
        chk(rq, $sformatf("rf_waddr vec %0d", i), {29'b0, rf_waddr}, {29'b0, VECS[i].wa});
        chk(rq, $sformatf("rf_wdata vec %0d", i), rf_wdata, VECS[i].wd);
      end
      chk(rq, $sformatf("exc_code vec %0d", i), {30'b0, exc_code}, {30'b0, VECS[i].exc});
      chk(rq, $sformatf("exc vec %0d", i), {31'b0, exc}, {31'b0, (VECS[i].exc != 2'd0)});
      chk(rq, $sformatf("illegal vec %0d", i), {31'b0, illegal}, {31'b0, (VECS[i].exc == 2'd1)});
      chk(rq, $sformatf("data access vec %0d", i), {31'b0, seen}, {31'b0, VECS[i].mem});
      if (VECS[i].mem && seen) begin
        chk(rq, $sformatf("dmem_addr vec %0d", i), s_a, VECS[i].ma);
        chk(rq, $sformatf("dmem_we vec %0d", i), {31'b0, s_we}, {31'b0, VECS[i].mwe});
        chk("R11", $sformatf("dmem_size vec %0d", i), {31'b0, s_sz}, {31'b0, VECS[i].msz});
        if (VECS[i].mwe)
          chk(rq, $sformatf("dmem_wdata vec %0d", i), s_d, VECS[i].mwd);
      end
      @(negedge clk);
      chk(rq, $sformatf("next pc vec %0d", i), pc, VECS[i].pcn);
      cnt = 1;
    end

    // R1: asynchronous reset in the middle of a run
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc after mid-run reset", pc, 32'h0);
    chk("R1", "retire after mid-run reset", {31'b0, retire}, 32'h0);
    chk("R1", "dmem_req after mid-run reset", {31'b0, dmem_req}, 32'h0);
    chk("R1", "rf_we after mid-run reset", {31'b0, rf_we}, 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule